// File: doc/BRIEF.md
# Hashed Indirect Branch Target Cache

This block predicts where an indirect branch will jump. It is a set-associative table of branch targets. The set index is a hash of three things: the branch address, a global history value and the targets of the most recently resolved indirect branches. Mixing in the path lets one branch keep several targets, one for each calling context. A lookup is purely combinational. The hit flag and the predicted target come back in the cycle the request is presented.

A resolved branch is written through a separate update port. The update carries its own history and path values: the ones in force before that branch joined the path. If the branch's tag is already in the indexed set, only that way's target is rewritten. Otherwise a way picked by a free-running LFSR takes the new tag and target. The path history itself is produced outside this block and arrives as a vector with a per-slot valid mask.

Top module: `itgt_cache`

## Requirements
- R1: After a clock edge with `rst_n` low, every way of every set is invalid. Every lookup then misses until an update is written.
- R2: The set index is the low log2(SETS) bits of a hash. The hash starts as the branch address shifted right by ALIGN_SHIFT. When HASH_GHR is 1, the global history value, zero-extended, is XORed into the hash.
- R3: When HASH_PATH is 1, each path slot p is also XORed into the hash. Slot 0 is the newest target and is bits [ADDR_W-1:0] of the path vector; slot p is bits [p*ADDR_W +: ADDR_W]. Before the XOR, slot p is shifted right by ALIGN_SHIFT + p*STEP, where STEP = floor(log2(SETS)) / PATH_LEN using integer division.
- R4: A path slot whose bit in the valid mask is 0 leaves the hash unchanged. Bit p of the mask belongs to slot p.
- R5: The tag is the low TAG_W bits of the branch address after the alignment shift. A lookup hits only on a valid way of the indexed set whose tag equals this tag, and it returns that way's target. On a miss, hit is 0 and the target output is 0.
- R6: On an update whose tag is already valid in the indexed set, only that way's target is rewritten. Its tag stays, and no other way changes.
- R7: On an update whose tag is absent from the indexed set, the way numbered (LFSR value mod WAYS) receives the tag and the target and becomes valid. The LFSR value used is the one held just before the writing edge.
- R8: The 16-bit LFSR is loaded with LFSR_SEED on each edge with `rst_n` low. On every other edge it becomes {q[14:0], q[15]^q[13]^q[12]^q[10]}, whether or not an update occurs.
- R9: A lookup in the same cycle as an update sees the table as it was before that update. The written data is visible from the next cycle.
- R10: The update index and tag are computed only from the update port's own address, history, path and mask inputs, independently of the lookup inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_pc | input | ADDR_W | Lookup branch address |
| lk_ghist | input | GHR_W | Lookup global history value |
| lk_path | input | PATH_LEN*ADDR_W | Lookup recent targets, slot 0 newest |
| lk_path_vld | input | PATH_LEN | Lookup path slot valid mask |
| lk_hit | output | 1 | Lookup found a matching valid way |
| lk_target | output | ADDR_W | Predicted target, 0 on miss |
| up_en | input | 1 | Write a resolved target this cycle |
| up_pc | input | ADDR_W | Update branch address |
| up_ghist | input | GHR_W | History in force before this branch |
| up_path | input | PATH_LEN*ADDR_W | Recent targets before this branch |
| up_path_vld | input | PATH_LEN | Update path slot valid mask |
| up_target | input | ADDR_W | Resolved target to store |

## Verification
The lookup and the update can land in the same cycle, and often on the same set. The bench deliberately presents, on one cycle, a lookup of the very branch being updated. It expects the pre-update answer, usually a miss, and then repeats the lookup a cycle later to confirm the new target. Filling one set past its way count at known points in the LFSR sequence makes the evicted ways predictable. Each sweep is therefore judged against a reference table that the bench keeps from the stated hash, tag and victim rules.

// File: rtl/itgt_pkg.sv
// Shared constants and helpers for the indirect target cache.
// Assumes a 16-bit victim LFSR is sufficient for any way count used.
package itgt_pkg;
    localparam int LFSR_W = 16;

    // Next state of the victim LFSR (taps 16,14,13,11).
    function automatic logic [LFSR_W-1:0] lfsr_advance(input logic [LFSR_W-1:0] q);
        return {q[LFSR_W-2:0], q[15] ^ q[13] ^ q[12] ^ q[10]};
    endfunction
endpackage

// File: rtl/itgt_index_hash.sv
// Computes the set index and tag of a branch from its address, global
// history and recent path targets. Purely combinational.
// Assumes SETS is a power of two and TAG_W <= ADDR_W - SHIFT.
module itgt_index_hash #(
    parameter int ADDR_W   = 32,
    parameter int GHR_W    = 8,
    parameter int PATH_LEN = 2,
    parameter int SETS     = 16,
    parameter int TAG_W    = 8,
    parameter int SHIFT    = 2,
    parameter bit USE_GHR  = 1'b1,
    parameter bit USE_PATH = 1'b1,
    localparam int IDX_W   = $clog2(SETS),
    localparam int STEP    = IDX_W / PATH_LEN
) (
    input  logic [ADDR_W-1:0]          pc,
    input  logic [GHR_W-1:0]           ghist,
    input  logic [PATH_LEN*ADDR_W-1:0] path,
    input  logic [PATH_LEN-1:0]        path_vld,
    output logic [IDX_W-1:0]           idx,
    output logic [TAG_W-1:0]           tag
);
    logic [ADDR_W-1:0] pc_aligned;
    logic [IDX_W-1:0]  hash;
    logic              unused_in_bits;

    assign pc_aligned     = pc >> SHIFT;
    assign tag            = pc_aligned[TAG_W-1:0];
    assign unused_in_bits = ^{pc, ghist, path};

    // Fold address, history and each valid path slot into the index.
    always_comb begin
        hash = pc_aligned[IDX_W-1:0];
        if (USE_GHR) begin
            hash = hash ^ IDX_W'(ghist);
        end
        for (int p = 0; p < PATH_LEN; p++) begin
            if (USE_PATH && path_vld[p]) begin
                hash = hash ^ IDX_W'(path[p*ADDR_W +: ADDR_W] >> (SHIFT + p*STEP));
            end
        end
        idx = hash;
    end
endmodule

// File: rtl/itgt_victim_lfsr.sv
// Free-running LFSR that names the way to replace on an allocation.
// Steps every cycle out of reset; victim is the state modulo WAYS.
module itgt_victim_lfsr
    import itgt_pkg::*;
#(
    parameter int              WAYS = 4,
    parameter logic [LFSR_W-1:0] SEED = 16'hACE1,
    localparam int             WAY_W = $clog2(WAYS)
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [LFSR_W-1:0] state,
    output logic [WAY_W-1:0]  victim
);
    // Load the seed in reset, otherwise advance one step.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= SEED;
        else        state <= lfsr_advance(state);
    end

    // Reduce the state to a way number.
    assign victim = WAY_W'(state % LFSR_W'(WAYS));
endmodule

// File: rtl/itgt_way_bank.sv
// One way of the cache: per-set valid bit, tag and target.
// Reads are combinational; a write lands on the clock edge, so a read in
// the same cycle returns the old contents.
module itgt_way_bank #(
    parameter int SETS   = 16,
    parameter int TAG_W  = 8,
    parameter int ADDR_W = 32,
    localparam int IDX_W = $clog2(SETS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [TAG_W-1:0]  rd_tag,
    output logic              rd_match,
    output logic [ADDR_W-1:0] rd_tgt,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [TAG_W-1:0]  wr_tag,
    output logic              wr_match,
    input  logic              wr_en,
    input  logic              wr_alloc,
    input  logic [ADDR_W-1:0] wr_tgt
);
    logic [SETS-1:0]   vld_q;
    logic [TAG_W-1:0]  tag_mem [SETS];
    logic [ADDR_W-1:0] tgt_mem [SETS];

    assign rd_match = vld_q[rd_idx] && (tag_mem[rd_idx] == rd_tag);
    assign rd_tgt   = tgt_mem[rd_idx];
    assign wr_match = vld_q[wr_idx] && (tag_mem[wr_idx] == wr_tag);

    // Clear valid bits in reset; mark a set valid when written.
    always_ff @(posedge clk) begin
        if (!rst_n)     vld_q <= '0;
        else if (wr_en) vld_q[wr_idx] <= 1'b1;
    end

    // Store the target always, the tag only on allocation.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            tgt_mem[wr_idx] <= wr_tgt;
            if (wr_alloc) tag_mem[wr_idx] <= wr_tag;
        end
    end
endmodule

// File: rtl/itgt_cache.sv
// Hashed set-associative indirect branch target cache.
// Lookup is combinational; update writes at the clock edge, rewriting a
// matching way or replacing an LFSR-chosen victim. Assumes SETS and WAYS
// are powers of two, WAYS >= 2, GHR_W <= ADDR_W.
module itgt_cache
    import itgt_pkg::*;
#(
    parameter int              SETS        = 16,
    parameter int              WAYS        = 4,
    parameter int              TAG_W       = 8,
    parameter int              PATH_LEN    = 2,
    parameter int              ALIGN_SHIFT = 2,
    parameter int              ADDR_W      = 32,
    parameter int              GHR_W       = 8,
    parameter bit              HASH_GHR    = 1'b1,
    parameter bit              HASH_PATH   = 1'b1,
    parameter logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [ADDR_W-1:0]          lk_pc,
    input  logic [GHR_W-1:0]           lk_ghist,
    input  logic [PATH_LEN*ADDR_W-1:0] lk_path,
    input  logic [PATH_LEN-1:0]        lk_path_vld,
    output logic                       lk_hit,
    output logic [ADDR_W-1:0]          lk_target,
    input  logic                       up_en,
    input  logic [ADDR_W-1:0]          up_pc,
    input  logic [GHR_W-1:0]           up_ghist,
    input  logic [PATH_LEN*ADDR_W-1:0] up_path,
    input  logic [PATH_LEN-1:0]        up_path_vld,
    input  logic [ADDR_W-1:0]          up_target
);
    localparam int IDX_W = $clog2(SETS);
    localparam int WAY_W = $clog2(WAYS);

    logic [IDX_W-1:0]  lk_idx, up_idx;
    logic [TAG_W-1:0]  lk_tag, up_tag;
    logic [WAYS-1:0]   lk_match, up_match, way_we;
    logic [ADDR_W-1:0] way_tgt [WAYS];
    logic [LFSR_W-1:0] lfsr_q;
    logic [WAY_W-1:0]  victim;
    logic              up_alloc;

    itgt_index_hash #(
        .ADDR_W(ADDR_W), .GHR_W(GHR_W), .PATH_LEN(PATH_LEN), .SETS(SETS),
        .TAG_W(TAG_W), .SHIFT(ALIGN_SHIFT), .USE_GHR(HASH_GHR), .USE_PATH(HASH_PATH)
    ) u_lk_hash (
        .pc(lk_pc), .ghist(lk_ghist), .path(lk_path), .path_vld(lk_path_vld),
        .idx(lk_idx), .tag(lk_tag)
    );

    itgt_index_hash #(
        .ADDR_W(ADDR_W), .GHR_W(GHR_W), .PATH_LEN(PATH_LEN), .SETS(SETS),
        .TAG_W(TAG_W), .SHIFT(ALIGN_SHIFT), .USE_GHR(HASH_GHR), .USE_PATH(HASH_PATH)
    ) u_up_hash (
        .pc(up_pc), .ghist(up_ghist), .path(up_path), .path_vld(up_path_vld),
        .idx(up_idx), .tag(up_tag)
    );

    itgt_victim_lfsr #(.WAYS(WAYS), .SEED(LFSR_SEED)) u_victim (
        .clk(clk), .rst_n(rst_n), .state(lfsr_q), .victim(victim)
    );

    // Allocate only when no way of the update set holds the tag.
    assign up_alloc = ~|up_match;

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        // Write the matching way, or the victim way on allocation.
        assign way_we[w] = up_en && (up_alloc ? (victim == WAY_W'(w)) : up_match[w]);

        itgt_way_bank #(.SETS(SETS), .TAG_W(TAG_W), .ADDR_W(ADDR_W)) u_bank (
            .clk(clk), .rst_n(rst_n),
            .rd_idx(lk_idx), .rd_tag(lk_tag), .rd_match(lk_match[w]), .rd_tgt(way_tgt[w]),
            .wr_idx(up_idx), .wr_tag(up_tag), .wr_match(up_match[w]),
            .wr_en(way_we[w]), .wr_alloc(up_alloc), .wr_tgt(up_target)
        );
    end

    assign lk_hit = |lk_match;

    // Select the target of the lowest matching way, zero on a miss.
    always_comb begin
        lk_target = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (lk_match[w]) lk_target = way_tgt[w];
        end
    end
endmodule

// File: rtl/itgt_cache_sva.sv
// Property checker for itgt_cache, attached by bind below.
module itgt_cache_sva #(
    parameter int WAYS   = 4,
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              lk_hit,
    input logic [ADDR_W-1:0] lk_target,
    input logic              up_en,
    input logic [WAYS-1:0]   way_we,
    input logic [WAYS-1:0]   lk_match,
    input logic [15:0]       lfsr_q
);
    a_r1_empty_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !lk_hit);
    a_r5_miss_target_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_hit |-> lk_target == '0);
    a_r5_single_match: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lk_match));
    a_r6_one_way_written: assert property (@(posedge clk) disable iff (!rst_n)
        up_en |-> $countones(way_we) == 1);
    a_r6_idle_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        !up_en |-> way_we == '0);
    a_r8_lfsr_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        lfsr_q != '0);
    a_r8_lfsr_steps: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> lfsr_q != $past(lfsr_q));
endmodule

bind itgt_cache itgt_cache_sva #(.WAYS(WAYS), .ADDR_W(ADDR_W)) u_sva (
    .clk(clk), .rst_n(rst_n), .lk_hit(lk_hit), .lk_target(lk_target),
    .up_en(up_en), .way_we(way_we), .lk_match(lk_match), .lfsr_q(lfsr_q)
);

// File: tb/itgt_cache_bench.sv
`timescale 1ns/1ps
module itgt_cache_bench;
    localparam logic [15:0] SEED = 16'hACE1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] lk_pc, up_pc, up_tgt;
    logic [7:0]  lk_gh, up_gh;
    logic [63:0] lk_path, up_path;
    logic [1:0]  lk_pv, up_pv;
    logic        up_en;
    logic        lk_hit;
    logic [31:0] lk_target;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Reference table: 16 sets x 4 ways.
    logic        mv [16][4];
    logic [7:0]  mt [16][4];
    logic [31:0] mg [16][4];
    logic [15:0] m_lfsr;

    always #5 clk = ~clk;

    itgt_cache #(.SETS(16), .WAYS(4), .TAG_W(8), .PATH_LEN(2), .ALIGN_SHIFT(2),
                 .ADDR_W(32), .GHR_W(8), .LFSR_SEED(SEED)) u_itgt_cache (
        .clk(clk), .rst_n(rst_n),
        .lk_pc(lk_pc), .lk_ghist(lk_gh), .lk_path(lk_path), .lk_path_vld(lk_pv),
        .lk_hit(lk_hit), .lk_target(lk_target),
        .up_en(up_en), .up_pc(up_pc), .up_ghist(up_gh), .up_path(up_path),
        .up_path_vld(up_pv), .up_target(up_tgt)
    );

    // R8 reference LFSR.
    always @(posedge clk) begin
        if (!rst_n) m_lfsr <= SEED;
        else        m_lfsr <= {m_lfsr[14:0], m_lfsr[15] ^ m_lfsr[13] ^ m_lfsr[12] ^ m_lfsr[10]};
    end

    // R2/R3/R4 index: step = log2(16)/2 = 2, so slot 1 shifts by 4.
    function automatic int m_index(input logic [31:0] pc, input logic [7:0] gh,
                                   input logic [63:0] path, input logic [1:0] pv);
        logic [31:0] h;
        h = (pc >> 2) ^ {24'h0, gh};
        if (pv[0]) h = h ^ (path[31:0] >> 2);
        if (pv[1]) h = h ^ (path[63:32] >> 4);
        return int'(h % 16);
    endfunction

    function automatic int m_find(input int idx, input logic [7:0] tg);
        for (int w = 0; w < 4; w++) if (mv[idx][w] && mt[idx][w] == tg) return w;
        return -1;
    endfunction

    task automatic check_lookup(input string req);
        int idx, w;
        logic eh;
        logic [31:0] et;
        idx = m_index(lk_pc, lk_gh, lk_path, lk_pv);
        w   = m_find(idx, lk_pc[9:2]);
        eh  = (w >= 0);
        et  = eh ? mg[idx][w] : 32'h0;
        checks++;
        if (lk_hit !== eh || lk_target !== et) begin
            errors++;
            $display("FAIL %s pc=%h: hit=%0b target=%h expected hit=%0b target=%h",
                     req, lk_pc, lk_hit, lk_target, eh, et);
        end
    endtask

    task automatic set_lk(input logic [31:0] pc, input logic [7:0] gh,
                          input logic [63:0] path, input logic [1:0] pv);
        lk_pc = pc; lk_gh = gh; lk_path = path; lk_pv = pv;
    endtask

    task automatic set_up(input logic en, input logic [31:0] pc, input logic [7:0] gh,
                          input logic [63:0] path, input logic [1:0] pv, input logic [31:0] tgt);
        up_en = en; up_pc = pc; up_gh = gh; up_path = path; up_pv = pv; up_tgt = tgt;
    endtask

    // One cycle: check the lookup before the edge (R9), then mirror the update.
    task automatic cycle(input string req);
        int ui, uw;
        bit alloc;
        #1;
        check_lookup(req);
        ui = 0; uw = 0; alloc = 0;
        if (up_en) begin
            ui = m_index(up_pc, up_gh, up_path, up_pv);
            uw = m_find(ui, up_pc[9:2]);
            alloc = (uw < 0);
            if (alloc) uw = int'(m_lfsr % 16'd4);
        end
        @(posedge clk);
        if (up_en) begin
            mv[ui][uw] = 1'b1;
            mg[ui][uw] = up_tgt;
            if (alloc) mt[ui][uw] = up_pc[9:2];
        end
        @(negedge clk);
    endtask

    initial begin
        for (int s = 0; s < 16; s++) for (int w = 0; w < 4; w++) mv[s][w] = 1'b0;
        set_lk(0, 0, 0, 0);
        set_up(0, 0, 0, 0, 0, 0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: empty table misses everywhere.
        for (int i = 0; i < 32; i++) begin
            set_lk(32'h100 + i * 32'h44, 8'(i), {32'(i * 13), 32'(i * 7)}, 2'(i));
            cycle("R1");
        end

        // R9 + R7: overfill set 5 (tags differ by multiples of 16); same-cycle lookup.
        for (int k = 0; k < 10; k++) begin
            set_up(1, 32'((k * 16 + 5) << 2), 0, 0, 0, 32'hA000_0000 + k);
            set_lk(32'((k * 16 + 5) << 2), 0, 0, 0);
            cycle("R9");
        end
        set_up(0, 0, 0, 0, 0, 0);
        for (int k = 0; k < 10; k++) begin
            set_lk(32'((k * 16 + 5) << 2), 0, 0, 0);
            cycle("R7");
        end

        // R8: idle cycles still step the LFSR; overfill set 9.
        repeat (5) cycle("R8");
        for (int k = 0; k < 9; k++) begin
            set_up(1, 32'((k * 16 + 9) << 2), 0, 0, 0, 32'hC000_0000 + k);
            cycle("R8");
        end
        set_up(0, 0, 0, 0, 0, 0);
        for (int k = 0; k < 9; k++) begin
            set_lk(32'((k * 16 + 9) << 2), 0, 0, 0);
            cycle("R8");
        end

        // R6: rewrite targets of present set-5 entries only.
        for (int k = 0; k < 10; k++) begin
            if (m_find(5, 8'(k * 16 + 5)) >= 0) begin
                set_up(1, 32'((k * 16 + 5) << 2), 0, 0, 0, 32'hB000_0000 + k);
                cycle("R6");
            end
        end
        set_up(0, 0, 0, 0, 0, 0);
        for (int k = 0; k < 10; k++) begin
            set_lk(32'((k * 16 + 5) << 2), 0, 0, 0);
            cycle("R6");
        end

        // R5: spread allocations; also aliasing address bit 10 (outside tag and index).
        for (int i = 0; i < 40; i++) begin
            set_up(1, (32'h4000_0000 + i * 32'h1234) & ~32'h3, 0, 0, 0, 32'h5000_0000 + i);
            cycle("R5");
        end
        set_up(0, 0, 0, 0, 0, 0);
        for (int i = 0; i < 40; i++) begin
            set_lk((32'h4000_0000 + i * 32'h1234) & ~32'h3, 0, 0, 0);
            cycle("R5");
            set_lk(((32'h4000_0000 + i * 32'h1234) & ~32'h3) ^ 32'h400, 0, 0, 0);
            cycle("R5");
        end

        // R2/R3/R4: history and path in the hash, all masks.
        for (int i = 0; i < 48; i++) begin
            logic [31:0] pc, p0, p1;
            logic [7:0]  gh;
            logic [1:0]  pv;
            pc = 32'h0800_0000 + i * 52;
            gh = 8'(i * 29);
            p0 = 32'(i) * 32'h9E37_79B9;
            p1 = ~p0 ^ 32'(i);
            pv = 2'(i);
            set_up(1, pc, gh, {p1, p0}, pv, 32'h7000_0000 + i);
            set_lk(pc, gh, {p1, p0}, pv);
            cycle("R3");
            set_up(0, 0, 0, 0, 0, 0);
            cycle("R3");
            set_lk(pc, gh ^ 8'h1, {p1, p0}, pv);
            cycle("R2");
            set_lk(pc, gh, {p1, p0}, pv ^ 2'b01);
            cycle("R4");
            set_lk(pc, gh, {p1, p0}, pv ^ 2'b10);
            cycle("R4");
        end

        // R10: update and lookup ports carry unrelated branches in one cycle.
        for (int i = 0; i < 16; i++) begin
            set_up(1, 32'h0900_0000 + i * 68, 8'(i * 5 + 3), {32'(i * 99), 32'(i * 1234567)},
                   2'b11, 32'h9000_0000 + i);
            set_lk(32'h0900_0000 + (i - 1) * 68, 8'(i * 5 - 2), {32'((i - 1) * 99),
                   32'((i - 1) * 1234567)}, 2'b11);
            cycle("R10");
        end
        set_up(0, 0, 0, 0, 0, 0);
        for (int i = 0; i < 16; i++) begin
            set_lk(32'h0900_0000 + i * 68, 8'(i * 5 + 3), {32'(i * 99), 32'(i * 1234567)}, 2'b11);
            cycle("R10");
        end

        // R1: reset again empties the table.
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        for (int s = 0; s < 16; s++) for (int w = 0; w < 4; w++) mv[s][w] = 1'b0;
        rst_n = 1'b1;
        for (int i = 0; i < 16; i++) begin
            set_lk((32'h4000_0000 + i * 32'h1234) & ~32'h3, 0, 0, 0);
            cycle("R1");
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(200000 * 10);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule